// File: doc/BRIEF.md
# Multi-Channel Reloading Down-Counter Timer

The block is a memory-mapped timer with two or three independent 32-bit channels. The channel count is fixed when the block is built. Each channel holds a reload value, a down-counting counter and a control word. The control word selects one of five prescaled count rates derived from the functional clock, enables the channel interrupt, and holds a sticky underflow flag. One shared start register carries a run bit per channel.

A running channel decrements once per tick of its selected rate. A tick that finds the counter at zero reloads the counter from the reload register, so the channel counts reload+1 ticks per period, and sets the underflow flag. The interrupt output of the channel is a level: the flag ANDed with the enable bit. Software can use a channel as a periodic tick source by loading the reload value. It can also use a channel as a free-running time base: with all ones in both registers, the inverted counter value counts upward. The first interval is loaded into the counter while the channel is stopped.

The bus is a plain synchronous byte-addressed register port. Writes are captured at the clock edge and reads are combinational from the current address.

Top module: `tick_timer`

## Requirements
- R1: After reset every reload and counter register reads 0xFFFFFFFF, every control register reads 0, the start register reads 0 and all interrupt outputs are low.
- R2: The start register is at byte 4 (byte 2 with ALT_MAP=1). Bit n of the start register runs channel n when it is 1 and stops channel n when it is 0. A write stores all channel bits at once, and bits at or above the channel count read as 0.
- R3: Channel n has its reload register at byte 8+12n, its counter at +4 and its control at +8 (the base becomes 4 with ALT_MAP=1). Any other address reads 0, and writes to it change nothing.
- R4: Control bits 2:0 pick the count rate: codes 0,1,2,3,4 give one tick every 4,16,64,256,1024 functional clocks, and codes 5 to 7 act as code 4. All ticks come from one shared divider that starts at reset, so any window of 4^(k+1) consecutive clocks holds exactly one tick of code k.
- R5: A running channel decrements its counter by one on each tick. A stopped channel holds its counter. A channel started with all ones reads, after bitwise inversion, the number of ticks it has seen.
- R6: A tick while the counter is 0 loads the counter from the reload register and sets the underflow flag (control bit 8).
- R7: A counter write takes effect only while the channel is stopped; a counter write to a running channel is ignored.
- R8: The underflow flag is sticky. A control write with bit 8 at 0 clears it, and a control write with bit 8 at 1 leaves it unchanged. An underflow in the same cycle as a clearing write leaves the flag set.
- R9: The interrupt output of channel n is high exactly while its underflow flag and its enable (control bit 5) are both 1.
- R10: A control read returns the stored rate code in bits 2:0, the enable in bit 5 and the flag in bit 8, with every other bit 0.
- R11: The reload register can be written at any time. A write changes only the value used by later reloads and leaves the counter untouched.
- R12: The channels run independently: a write to one channel's registers, or a tick on one channel, does not change another channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously to clk |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the current address, 0 when not selected |
| irq | output | NUM_CH | Level interrupt per channel |

## Verification
The hardest case to reach is a write that clears the underflow flag in the very clock edge where the same channel underflows. The outcome then depends on which of the two wins. To reach it, the bench runs one channel at the fastest rate with reload 0, so the channel underflows every fourth clock. It then issues clearing control writes on eight consecutive clocks, so at least one of them lands on an underflow edge. A behavioural model tracks the divider phase independently and checks every cycle, so the bench does not need to know which write collides. Rate checks sample a counter twice, exactly one divider period apart, and require a difference of exactly one, whatever the phase.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int PSEL_W    = 3;
  localparam int RATES     = 5;
  localparam int RATE_STEP = 2;
  localparam int CTL_IE    = 5;
  localparam int CTL_UF    = 8;
  localparam int REG_STEP  = 4;

  typedef struct packed {
    logic              uf_flag;
    logic              irq_en;
    logic [PSEL_W-1:0] psel;
  } ctl_t;
endpackage

// File: rtl/tick_prescale.sv
module tick_prescale
  import tick_timer_pkg::*;
#(
  parameter int N_RATES = RATES,
  parameter int STEP    = RATE_STEP
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic [N_RATES-1:0] tick_o
);
  localparam int PW = N_RATES * STEP;

  logic [PW-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  for (genvar k = 0; k < N_RATES; k++) begin : g_rate
    assign tick_o[k] = &pre_q[(k+1)*STEP-1:0];
  end
endmodule

// File: rtl/tick_channel.sv
module tick_channel
  import tick_timer_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32,
  parameter int N_RATES = RATES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic [N_RATES-1:0] tick_vec_i,
  input  logic               wr_rld_i,
  input  logic               wr_cnt_i,
  input  logic               wr_ctl_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rld_o,
  output logic [DATA_W-1:0]  cnt_o,
  output logic [DATA_W-1:0]  ctl_o,
  output logic               irq_o
);
  logic [CNT_W-1:0]  cnt_q, cnt_d, rld_q, rld_d;
  ctl_t              ctl_q, ctl_d;
  logic [PSEL_W-1:0] eff_sel;
  logic              tick_sel, step, uf;

  always_comb begin
    eff_sel  = (ctl_q.psel >= PSEL_W'(N_RATES)) ? PSEL_W'(N_RATES-1) : ctl_q.psel;
    tick_sel = tick_vec_i[eff_sel];
    step     = run_i & tick_sel;
    uf       = step & (cnt_q == '0);
  end

  always_comb begin
    cnt_d = cnt_q;
    if (step)                   cnt_d = uf ? rld_q : cnt_q - CNT_W'(1);
    else if (wr_cnt_i && !run_i) cnt_d = wdata_i[CNT_W-1:0];

    rld_d = rld_q;
    if (wr_rld_i) rld_d = wdata_i[CNT_W-1:0];

    ctl_d = ctl_q;
    if (wr_ctl_i) begin
      ctl_d.psel    = wdata_i[PSEL_W-1:0];
      ctl_d.irq_en  = wdata_i[CTL_IE];
      ctl_d.uf_flag = ctl_q.uf_flag & wdata_i[CTL_UF];
    end
    if (uf) ctl_d.uf_flag = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '1;
      rld_q <= '1;
      ctl_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      rld_q <= rld_d;
      ctl_q <= ctl_d;
    end
  end

  always_comb begin
    rld_o = '0;
    rld_o[CNT_W-1:0] = rld_q;
    cnt_o = '0;
    cnt_o[CNT_W-1:0] = cnt_q;
    ctl_o = '0;
    ctl_o[PSEL_W-1:0] = ctl_q.psel;
    ctl_o[CTL_IE]     = ctl_q.irq_en;
    ctl_o[CTL_UF]     = ctl_q.uf_flag;
    irq_o = ctl_q.uf_flag & ctl_q.irq_en;
  end

  // R5: a stopped channel with no counter write keeps its count
  assert_hold_stopped_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_cnt_i) |=> $stable(cnt_q));

  // R6: a tick at zero reloads and raises the flag
  assert_underflow_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && tick_sel && cnt_q == '0) |=> (cnt_q == $past(rld_q) && ctl_q.uf_flag));

  // R7: a counter write to a running channel without a tick changes nothing
  assert_busy_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && !tick_sel && wr_cnt_i) |=> $stable(cnt_q));

  // R8: the flag only falls through a control write carrying bit 8 low
  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.uf_flag && !(wr_ctl_i && !wdata_i[CTL_UF])) |=> ctl_q.uf_flag);
endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_timer_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter bit ALT_MAP = 1'b0,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int CNT_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  localparam int START_OFS = ALT_MAP ? 2 : 4;
  localparam int CH_BASE   = ALT_MAP ? 4 : 8;
  localparam int CH_STRIDE = 3 * REG_STEP;

  logic [RATES-1:0]  ticks;
  logic [NUM_CH-1:0] run_q, run_d;
  logic              hit_start;
  logic [NUM_CH-1:0] hit_rld, hit_cnt, hit_ctl;
  logic [DATA_W-1:0] rld_v [NUM_CH];
  logic [DATA_W-1:0] cnt_v [NUM_CH];
  logic [DATA_W-1:0] ctl_v [NUM_CH];

  tick_prescale #(.N_RATES(RATES), .STEP(RATE_STEP)) u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (ticks)
  );

  assign hit_start = bus_sel && (bus_addr == ADDR_W'(START_OFS));

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;

    assign hit_rld[g] = bus_sel && (bus_addr == ADDR_W'(BASE));
    assign hit_cnt[g] = bus_sel && (bus_addr == ADDR_W'(BASE + REG_STEP));
    assign hit_ctl[g] = bus_sel && (bus_addr == ADDR_W'(BASE + 2*REG_STEP));

    tick_channel #(.DATA_W(DATA_W), .CNT_W(CNT_W), .N_RATES(RATES)) u_ch (
      .clk        (clk),
      .rst_n      (rst_n),
      .run_i      (run_q[g]),
      .tick_vec_i (ticks),
      .wr_rld_i   (hit_rld[g] & bus_wr),
      .wr_cnt_i   (hit_cnt[g] & bus_wr),
      .wr_ctl_i   (hit_ctl[g] & bus_wr),
      .wdata_i    (bus_wdata),
      .rld_o      (rld_v[g]),
      .cnt_o      (cnt_v[g]),
      .ctl_o      (ctl_v[g]),
      .irq_o      (irq[g])
    );
  end

  always_comb begin
    run_d = run_q;
    if (hit_start && bus_wr) run_d = bus_wdata[NUM_CH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_start) bus_rdata[NUM_CH-1:0] = run_q;
    for (int i = 0; i < NUM_CH; i++) begin
      if (hit_rld[i]) bus_rdata = rld_v[i];
      if (hit_cnt[i]) bus_rdata = cnt_v[i];
      if (hit_ctl[i]) bus_rdata = ctl_v[i];
    end
  end

  // R2: run bits move only through a write to the start register
  assert_run_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit_start && bus_wr) |=> $stable(run_q));

  // R3: at most one register answers any address
  assert_one_decode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({hit_start, hit_rld, hit_cnt, hit_ctl}) <= 1);
endmodule

// File: tb/tick_timer_tb_top.sv
module tick_timer_tb_top;
  localparam int NCH = 3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        b_sel, b_wr;
  logic [7:0]  b_addr;
  logic [31:0] b_wdata;
  logic [31:0] bus_rdata;
  logic [NCH-1:0] irq;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tick_timer #(.NUM_CH(NCH)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (b_sel),
    .bus_wr    (b_wr),
    .bus_addr  (b_addr),
    .bus_wdata (b_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  function automatic int a_rld(int c); return 8 + 12*c; endfunction
  function automatic int a_cnt(int c); return 12 + 12*c; endfunction
  function automatic int a_ctl(int c); return 16 + 12*c; endfunction
  localparam int A_RUN = 4;

  // behavioural reference
  logic [31:0] m_rld [NCH];
  logic [31:0] m_cnt [NCH];
  logic [2:0]  m_psel [NCH];
  bit          m_ie [NCH];
  bit          m_flag [NCH];
  logic [NCH-1:0] m_run;
  int          m_pre;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < NCH; c++) begin
        m_rld[c] = '1; m_cnt[c] = '1; m_psel[c] = 0; m_ie[c] = 0; m_flag[c] = 0;
      end
      m_run = '0;
      m_pre = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        int  code, div;
        bit  tk, nf;
        logic [31:0] nc;
        code = (m_psel[c] > 3'd4) ? 4 : int'(m_psel[c]);
        div  = 4 << (2*code);
        tk   = m_run[c] && ((m_pre % div) == div - 1);
        nf   = m_flag[c];
        nc   = m_cnt[c];
        if (b_sel && b_wr && int'(b_addr) == a_ctl(c)) begin
          nf = m_flag[c] && b_wdata[8];
          m_psel[c] = b_wdata[2:0];
          m_ie[c]   = b_wdata[5];
        end
        if (tk) begin
          if (m_cnt[c] == 0) begin nc = m_rld[c]; nf = 1; end
          else nc = m_cnt[c] - 1;
        end else if (b_sel && b_wr && int'(b_addr) == a_cnt(c) && !m_run[c]) begin
          nc = b_wdata;
        end
        if (b_sel && b_wr && int'(b_addr) == a_rld(c)) m_rld[c] = b_wdata;
        m_cnt[c]  = nc;
        m_flag[c] = nf;
      end
      if (b_sel && b_wr && int'(b_addr) == A_RUN) m_run = b_wdata[NCH-1:0];
      m_pre = (m_pre + 1) % 1024;
    end
  end

  function automatic logic [31:0] m_read(int a);
    if (a == A_RUN) return {29'b0, m_run};
    for (int c = 0; c < NCH; c++) begin
      if (a == a_rld(c)) return m_rld[c];
      if (a == a_cnt(c)) return m_cnt[c];
      if (a == a_ctl(c)) return {23'b0, m_flag[c], 2'b0, m_ie[c], 2'b0, m_psel[c]};
    end
    return 32'h0;
  endfunction

  function automatic string tag_of(int a);
    if (a == A_RUN) return "R2";
    for (int c = 0; c < NCH; c++) begin
      if (a == a_rld(c)) return "R11";
      if (a == a_cnt(c)) return "R5";
      if (a == a_ctl(c)) return "R10";
    end
    return "R3";
  endfunction

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [NCH-1:0] ei;
      for (int c = 0; c < NCH; c++) ei[c] = m_flag[c] && m_ie[c];
      chk("R9", 32'(irq), 32'(ei));
      chk(tag_of(int'(b_addr)), bus_rdata, b_sel ? m_read(int'(b_addr)) : 32'h0);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(int a, logic [31:0] d);
    b_sel = 1; b_wr = 1; b_addr = 8'(a); b_wdata = d;
    @(posedge clk); #2;
    b_sel = 0; b_wr = 0;
  endtask

  task automatic idle(int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic rd_get(int a, output logic [31:0] v);
    b_sel = 1; b_wr = 0; b_addr = 8'(a);
    @(negedge clk);
    v = bus_rdata;
    @(posedge clk); #2;
    b_sel = 0;
  endtask

  task automatic rd_hard(int a, logic [31:0] exp, string tag);
    logic [31:0] v;
    rd_get(a, v);
    chk(tag, v, exp);
  endtask

  task automatic rd_model(int a, string tag);
    logic [31:0] e, v;
    b_sel = 1; b_wr = 0; b_addr = 8'(a);
    @(negedge clk);
    v = bus_rdata;
    e = m_read(a);
    chk(tag, v, e);
    @(posedge clk); #2;
    b_sel = 0;
  endtask

  initial begin
    logic [31:0] v0, v1;
    rst_n = 0; b_sel = 0; b_wr = 0; b_addr = 0; b_wdata = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    idle(1);

    // R1 reset state
    rd_hard(A_RUN, 32'h0, "R1");
    rd_hard(a_rld(0), 32'hFFFF_FFFF, "R1");
    rd_hard(a_cnt(0), 32'hFFFF_FFFF, "R1");
    rd_hard(a_ctl(2), 32'h0, "R1");
    chk("R1", 32'(irq), 32'h0);

    // R10 control field layout
    wr(a_ctl(1), 32'hFFFF_FFFF);
    rd_hard(a_ctl(1), 32'h0000_0027, "R10");
    wr(a_ctl(1), 32'h0000_0001);
    rd_hard(a_ctl(1), 32'h0000_0001, "R10");

    // R7 counter write while stopped
    wr(a_cnt(0), 32'd5);
    rd_hard(a_cnt(0), 32'd5, "R7");
    wr(a_rld(0), 32'd9);
    wr(a_ctl(0), 32'h20);
    wr(a_rld(1), 32'd2);
    wr(a_cnt(1), 32'd2);
    wr(a_rld(2), 32'd0);
    wr(a_cnt(2), 32'd0);
    wr(a_ctl(2), 32'h7);

    // R6 R9 R12: only channel 0 runs
    wr(A_RUN, 32'h1);
    idle(100);
    rd_hard(A_RUN, 32'h1, "R2");
    rd_model(a_cnt(1), "R12");
    chk("R9", 32'(irq[0]), 32'h1);
    chk("R12", 32'(irq[2:1]), 32'h0);

    // R8 writing 1 to the flag keeps it, writing 0 clears it
    wr(a_ctl(0), 32'h120);
    rd_hard(a_ctl(0), 32'h120, "R8");
    wr(a_ctl(0), 32'h020);
    rd_model(a_ctl(0), "R8");

    // R2 all run bits, upper bits read zero
    wr(A_RUN, 32'hFF);
    rd_hard(A_RUN, 32'h7, "R2");
    idle(2100);
    rd_model(a_ctl(2), "R6");

    // R7 counter write to running channel ignored
    wr(a_cnt(1), 32'h0000_ABCD);
    rd_get(a_cnt(1), v0);
    chk("R7", 32'(v0 == 32'h0000_ABCD), 32'h0);
    rd_model(a_cnt(1), "R7");

    // R11 reload change while running
    wr(a_rld(0), 32'd3);
    rd_model(a_cnt(0), "R11");
    idle(60);
    rd_model(a_cnt(0), "R11");

    // R8 clear colliding with underflow: reload 0 at the fastest rate
    wr(a_rld(0), 32'd0);
    idle(8);
    for (int i = 0; i < 8; i++) wr(a_ctl(0), 32'h020);
    for (int i = 0; i < 6; i++) rd_model(a_ctl(0), "R8");

    // R5 stopped channel holds
    wr(A_RUN, 32'h6);
    rd_get(a_cnt(0), v0);
    idle(50);
    rd_hard(a_cnt(0), v0, "R5");

    // R3 unmapped addresses
    wr(8'h30, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    rd_hard(8'h30, 32'h0, "R3");
    rd_hard(8'h05, 32'h0, "R3");
    rd_model(A_RUN, "R3");

    // R5 free-running up-count through inversion
    wr(A_RUN, 32'h4);
    wr(a_rld(1), 32'hFFFF_FFFF);
    wr(a_cnt(1), 32'hFFFF_FFFF);
    wr(a_ctl(1), 32'h0);
    wr(A_RUN, 32'h6);
    idle(40);
    rd_get(a_cnt(1), v0);
    chk("R5", 32'((~v0 >= 9) && (~v0 <= 11)), 32'h1);

    // R4 rates: one tick per window of the divide ratio
    wr(a_ctl(1), 32'h2);
    rd_get(a_cnt(1), v0);
    idle(63);
    rd_get(a_cnt(1), v1);
    chk("R4", v0 - v1, 32'd1);
    wr(a_ctl(1), 32'h4);
    rd_get(a_cnt(1), v0);
    idle(1023);
    rd_get(a_cnt(1), v1);
    chk("R4", v0 - v1, 32'd1);
    wr(a_ctl(1), 32'h6);
    rd_get(a_cnt(1), v0);
    idle(1023);
    rd_get(a_cnt(1), v1);
    chk("R4", v0 - v1, 32'd1);
    wr(a_ctl(1), 32'h1);
    rd_get(a_cnt(1), v0);
    idle(15);
    rd_get(a_cnt(1), v1);
    chk("R4", v0 - v1, 32'd1);

    idle(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule